// File: doc/BRIEF.md
# Compare-Driven Waveform Timer Channel

This block is one timer channel that counts either upward only or upward then downward. It produces two output lines, `tioA` and `tioB`, whose levels change in response to several sources: compare matches against three programmable values, a selectable external event edge, and a software trigger command. The count rate comes from a free-running divider of the system clock or from the rising edges of one of three external clock lines. Clock enable, clock disable and software trigger arrive as one-cycle command pulses.

Each output has a separate 2-bit action code for each of its four sources, so the shape of the waveform is set entirely by configuration. PWM is the usual use: one compare value sets the period, another sets the duty point, and the external event or the software trigger restarts the cycle. A sticky status vector records compare matches and counter overflow. The surrounding logic clears it with a read strobe.

Top module: `wtimer_chan`

## Requirements
- R1: After reset, `tioA`, `tioB`, `cntVal`, `status` and `clkOn` are all zero.
- R2: A `cmdClkEn` pulse sets `clkOn`, and a `cmdClkDis` pulse clears it. Disable wins when both arrive in the same cycle. While `clkOn` is low the count holds and both outputs are low.
- R3: `clkSel` codes 0 to 4 advance the count once every 2, 8, 32, 128 and 1024 system clocks respectively. Codes 5, 6 and 7 advance it on each rising edge of `extClk[0]`, `extClk[1]` and `extClk[2]`. Clock lines that are not selected have no effect.
- R4: With `waveSel` = 0 the count increments by one per count tick and wraps from all-ones to zero. Status bit 0 (overflow) is set by any tick taken from the all-ones value.
- R5: With `waveSel` = 2, a tick taken while the count equals `rcVal` returns the count to zero.
- R6: `waveSel` bit 0 selects up-down counting. The count turns downward at all-ones, and also at `rcVal` when `waveSel` = 3. It turns upward again at zero, so the value after zero is one.
- R7: While the clock is enabled, a `cmdSwTrig` pulse restarts the count at zero, counting upward. So does a selected event edge when `evtTrigEn` is high. A trigger takes precedence over a count tick in the same cycle. Triggers are ignored while the clock is disabled.
- R8: `evtSrc` 0 selects `tiobIn`, and `evtSrc` 1 to 3 select `extClk[0..2]`. `evtEdge` 0 detects no edge, 1 detects rising, 2 detects falling and 3 detects both.
- R9: `actCfgA` and `actCfgB` hold four 2-bit action fields. Bits [1:0] act on the own compare (A compares with `raVal`, B with `rbVal`), bits [3:2] on the RC compare, bits [5:4] on the event and bits [7:6] on the software trigger. The codes are 0 none, 1 set, 2 clear and 3 toggle.
- R10: When several sources are active on one output in the same cycle, the one with the highest priority among those whose code is not "none" applies. The order is software trigger, then event, then RC compare, then own compare. With no such source the output holds.
- R11: A compare match is a count tick taken while the count equals the compare value. Status bits 1, 2 and 3 record matches with `raVal`, `rbVal` and `rcVal`. Status bits stay set until a `statusRd` pulse, and a match in the same cycle as the read is kept.
- R12: An RC match with `stopOnRc` high halts counting until a trigger or an enable command. An RC match with `disOnRc` high clears `clkOn`. In both cases the tick that matched still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkSel | input | 3 | Count rate select |
| extClk | input | 3 | External clock lines |
| tiobIn | input | 1 | Event line for event source 0 |
| cmdClkEn | input | 1 | Clock enable command pulse |
| cmdClkDis | input | 1 | Clock disable command pulse |
| cmdSwTrig | input | 1 | Software trigger command pulse |
| waveSel | input | 2 | Bit 0 up-down, bit 1 RC trigger |
| evtSrc | input | 2 | Event source select |
| evtEdge | input | 2 | Event edge select |
| evtTrigEn | input | 1 | Event also restarts the count |
| stopOnRc | input | 1 | Halt counting on RC match |
| disOnRc | input | 1 | Disable clock on RC match |
| raVal | input | CNT_W | Compare value for output A |
| rbVal | input | CNT_W | Compare value for output B |
| rcVal | input | CNT_W | Shared RC compare value |
| actCfgA | input | 8 | Action fields for output A |
| actCfgB | input | 8 | Action fields for output B |
| statusRd | input | 1 | Status read-and-clear strobe |
| cntVal | output | CNT_W | Current count |
| tioA | output | 1 | Waveform output A |
| tioB | output | 1 | Waveform output B |
| status | output | 4 | Sticky flags: 0 overflow, 1 RA, 2 RB, 3 RC |
| clkOn | output | 1 | Counter clock enabled |

## Verification
The bench builds the channel with `CNT_W` = 4. At that width the all-ones wrap, the overflow flag and the all-ones reversal in up-down mode are all reached within sixteen count ticks. Most tests use external clock 0 as the count source, so each tick is placed on an exact cycle. The divide-by-2 and divide-by-8 taps are measured over fixed windows. The action and priority rules are covered by a table in which compare values of zero make the compare sources fire on the first tick after a restart.

// File: rtl/wtimer_pkg.sv
package wtimer_pkg;

  // Divider taps of the internal count rate and number of external clock lines
  localparam int NUM_DIV = 5;
  localparam int NUM_EXT = 3;
  localparam int SEL_W   = $clog2(NUM_DIV + NUM_EXT);
  localparam int NUM_OUT = 2;

  // Low bits of the prescaler that must be all ones for tap i
  function automatic int divLog(input int i);
    return (i == NUM_DIV - 1) ? 10 : 2 * i + 1;
  endfunction

  localparam int PRE_W = divLog(NUM_DIV - 1);

  // Action field positions inside an action configuration byte
  localparam int FLD_CMP = 0;
  localparam int FLD_RC  = 2;
  localparam int FLD_EVT = 4;
  localparam int FLD_SW  = 6;

  // Status bit positions
  localparam int ST_OVF = 0;
  localparam int ST_CPA = 1;
  localparam int ST_CPB = 2;
  localparam int ST_CPC = 3;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } outAct_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic tick;   // count advances this cycle
    logic trig;   // restart from zero, counting up
    logic evt;    // selected event edge seen while enabled
    logic sw;     // software trigger seen while enabled
    logic outEn;  // clock enable state after this edge
  } tmrStrobe_t;

  function automatic logic applyAct(input logic cur, input outAct_e act);
    case (act)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/wtimer_ctl.sv
module wtimer_ctl
  import wtimer_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   clkSel,
  input  logic [NUM_EXT-1:0] extClk,
  input  logic               tiobIn,
  input  logic               cmdClkEn,
  input  logic               cmdClkDis,
  input  logic               cmdSwTrig,
  input  logic [1:0]         evtSrc,
  input  logic [1:0]         evtEdge,
  input  logic               evtTrigEn,
  input  logic               stopOnRc,
  input  logic               disOnRc,
  input  logic               rcHit,
  output tmrStrobe_t         stb,
  output logic               clkOn
);

  logic [PRE_W-1:0]           preCnt;
  logic [NUM_DIV-1:0]         divTick;
  logic [NUM_EXT-1:0]         extPrev;
  logic [NUM_EXT-1:0]         extRise;
  logic [NUM_DIV+NUM_EXT-1:0] tickSrc;
  logic                       selTick;
  logic [NUM_EXT:0]           evtVec;
  logic                       evtLvl;
  logic                       evtPrev;
  logic                       evtHit;
  logic                       stopped;
  logic                       trigNow;
  logic                       clkOnNxt;
  logic                       stoppedNxt;

  // Divider taps from the free-running prescaler
  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    localparam int LG = divLog(i);
    assign divTick[i] = &preCnt[LG-1:0];
  end

  assign extRise = extClk & ~extPrev;
  assign tickSrc = {extRise, divTick};
  assign selTick = tickSrc[clkSel];

  // Event edge detection on the selected line
  assign evtVec = {extClk, tiobIn};
  assign evtLvl = evtVec[evtSrc];
  assign evtHit = (evtEdge[0] & evtLvl & ~evtPrev) |
                  (evtEdge[1] & ~evtLvl & evtPrev);

  assign trigNow = clkOn & (cmdSwTrig | (evtHit & evtTrigEn));

  always_comb begin
    clkOnNxt = clkOn;
    if (cmdClkDis)            clkOnNxt = 1'b0;
    else if (cmdClkEn)        clkOnNxt = 1'b1;
    else if (rcHit & disOnRc) clkOnNxt = 1'b0;
  end

  always_comb begin
    stoppedNxt = stopped;
    if (cmdClkEn | trigNow)    stoppedNxt = 1'b0;
    else if (rcHit & stopOnRc) stoppedNxt = 1'b1;
  end

  always_comb begin
    stb.trig  = trigNow;
    stb.tick  = clkOn & ~stopped & selTick & ~trigNow;
    stb.evt   = clkOn & evtHit;
    stb.sw    = clkOn & cmdSwTrig;
    stb.outEn = clkOnNxt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      extPrev <= '0;
      evtPrev <= 1'b0;
      clkOn   <= 1'b0;
      stopped <= 1'b0;
    end else begin
      preCnt  <= preCnt + 1'b1;
      extPrev <= extClk;
      evtPrev <= evtLvl;
      clkOn   <= clkOnNxt;
      stopped <= stoppedNxt;
    end
  end

endmodule

// File: rtl/wtimer_dp.sv
module wtimer_dp
  import wtimer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       stb,
  input  logic [1:0]       waveSel,
  input  logic [CNT_W-1:0] raVal,
  input  logic [CNT_W-1:0] rbVal,
  input  logic [CNT_W-1:0] rcVal,
  input  logic [7:0]       actCfgA,
  input  logic [7:0]       actCfgB,
  input  logic             statusRd,
  output logic [CNT_W-1:0] cntVal,
  output logic             tioA,
  output logic             tioB,
  output logic [3:0]       status,
  output logic             rcHit
);

  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] ALL_ONE = '1;

  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cntNxt;
  logic               dnDir;
  logic               dnNxt;
  logic               hitA;
  logic               hitB;
  logic               hitMax;
  logic               atTop;
  logic [3:0]         statusNxt;
  logic [7:0]         cfgArr [NUM_OUT];
  logic [NUM_OUT-1:0] cmpHit;
  logic [NUM_OUT-1:0] tioR;

  assign hitA   = stb.tick & (cnt == raVal);
  assign hitB   = stb.tick & (cnt == rbVal);
  assign rcHit  = stb.tick & (cnt == rcVal);
  assign hitMax = stb.tick & (cnt == ALL_ONE);
  assign atTop  = (cnt == ALL_ONE) | (waveSel[1] & (cnt == rcVal));

  always_comb begin
    cntNxt = cnt;
    dnNxt  = dnDir;
    if (stb.trig) begin
      cntNxt = '0;
      dnNxt  = 1'b0;
    end else if (stb.tick) begin
      if (!waveSel[0]) begin
        cntNxt = (waveSel[1] && cnt == rcVal) ? '0 : cnt + ONE;
      end else if (!dnDir) begin
        if (!atTop) begin
          cntNxt = cnt + ONE;
        end else if (cnt != '0) begin
          cntNxt = cnt - ONE;
          dnNxt  = 1'b1;
        end
      end else if (cnt == '0) begin
        cntNxt = ONE;
        dnNxt  = 1'b0;
      end else begin
        cntNxt = cnt - ONE;
      end
    end
  end

  always_comb begin
    statusNxt         = statusRd ? 4'd0 : status;
    statusNxt[ST_OVF] = statusNxt[ST_OVF] | hitMax;
    statusNxt[ST_CPA] = statusNxt[ST_CPA] | hitA;
    statusNxt[ST_CPB] = statusNxt[ST_CPB] | hitB;
    statusNxt[ST_CPC] = statusNxt[ST_CPC] | rcHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      dnDir  <= 1'b0;
      status <= '0;
    end else begin
      cnt    <= cntNxt;
      dnDir  <= dnNxt;
      status <= statusNxt;
    end
  end

  // Later checks override earlier ones, giving the priority order
  function automatic logic [1:0] pickAct(input logic [7:0] cfg, input logic sw,
                                         input logic ev, input logic rc,
                                         input logic cp);
    logic [1:0] r;
    r = 2'd0;
    if (cp && cfg[FLD_CMP+:2] != 2'd0) r = cfg[FLD_CMP+:2];
    if (rc && cfg[FLD_RC+:2]  != 2'd0) r = cfg[FLD_RC+:2];
    if (ev && cfg[FLD_EVT+:2] != 2'd0) r = cfg[FLD_EVT+:2];
    if (sw && cfg[FLD_SW+:2]  != 2'd0) r = cfg[FLD_SW+:2];
    return r;
  endfunction

  assign cfgArr[0] = actCfgA;
  assign cfgArr[1] = actCfgB;
  assign cmpHit    = {hitB, hitA};

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    logic [1:0] actSel;
    logic       outQ;
    always_comb actSel = pickAct(cfgArr[g], stb.sw, stb.evt, rcHit, cmpHit[g]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) outQ <= 1'b0;
      else       outQ <= stb.outEn ? applyAct(outQ, outAct_e'(actSel)) : 1'b0;
    end
    assign tioR[g] = outQ;
  end

  assign cntVal = cnt;
  assign tioA   = tioR[0];
  assign tioB   = tioR[1];

endmodule

// File: rtl/wtimer_chan.sv
module wtimer_chan
  import wtimer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   clkSel,
  input  logic [NUM_EXT-1:0] extClk,
  input  logic               tiobIn,
  input  logic               cmdClkEn,
  input  logic               cmdClkDis,
  input  logic               cmdSwTrig,
  input  logic [1:0]         waveSel,
  input  logic [1:0]         evtSrc,
  input  logic [1:0]         evtEdge,
  input  logic               evtTrigEn,
  input  logic               stopOnRc,
  input  logic               disOnRc,
  input  logic [CNT_W-1:0]   raVal,
  input  logic [CNT_W-1:0]   rbVal,
  input  logic [CNT_W-1:0]   rcVal,
  input  logic [7:0]         actCfgA,
  input  logic [7:0]         actCfgB,
  input  logic               statusRd,
  output logic [CNT_W-1:0]   cntVal,
  output logic               tioA,
  output logic               tioB,
  output logic [3:0]         status,
  output logic               clkOn
);

  tmrStrobe_t stb;
  logic       rcHit;

  wtimer_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .clkSel    (clkSel),
    .extClk    (extClk),
    .tiobIn    (tiobIn),
    .cmdClkEn  (cmdClkEn),
    .cmdClkDis (cmdClkDis),
    .cmdSwTrig (cmdSwTrig),
    .evtSrc    (evtSrc),
    .evtEdge   (evtEdge),
    .evtTrigEn (evtTrigEn),
    .stopOnRc  (stopOnRc),
    .disOnRc   (disOnRc),
    .rcHit     (rcHit),
    .stb       (stb),
    .clkOn     (clkOn)
  );

  wtimer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .waveSel  (waveSel),
    .raVal    (raVal),
    .rbVal    (rbVal),
    .rcVal    (rcVal),
    .actCfgA  (actCfgA),
    .actCfgB  (actCfgB),
    .statusRd (statusRd),
    .cntVal   (cntVal),
    .tioA     (tioA),
    .tioB     (tioB),
    .status   (status),
    .rcHit    (rcHit)
  );

endmodule

// File: rtl/wtimer_chan_chk.sv
module wtimer_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdSwTrig,
  input logic             evtTrigEn,
  input logic [1:0]       waveSel,
  input logic             statusRd,
  input logic [CNT_W-1:0] cntVal,
  input logic             tioA,
  input logic             tioB,
  input logic [3:0]       status,
  input logic             clkOn
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R2: outputs stay low while the counter clock is off
  a_r2_quiet_off: assert property (@(posedge clk) disable iff (!rstN)
    !clkOn |-> (!tioA && !tioB));

  // R2: the count holds across an edge taken with the clock off
  a_r2_hold_off: assert property (@(posedge clk) disable iff (!rstN)
    !clkOn |=> $stable(cntVal));

  // R4: in up-only mode without triggers the count moves by at most one
  a_r4_up_step: assert property (@(posedge clk) disable iff (!rstN)
    (clkOn && waveSel == 2'b00 && !cmdSwTrig && !evtTrigEn)
    |=> (cntVal == $past(cntVal) || cntVal == $past(cntVal) + ONE));

  // R7: a software trigger while enabled restarts at zero
  a_r7_sw_restart: assert property (@(posedge clk) disable iff (!rstN)
    (clkOn && cmdSwTrig) |=> (cntVal == '0));

  // R11: without a read strobe no status bit is lost
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !statusRd |=> ((status & $past(status)) == $past(status)));

endmodule

bind wtimer_chan wtimer_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdSwTrig (cmdSwTrig),
  .evtTrigEn (evtTrigEn),
  .waveSel   (waveSel),
  .statusRd  (statusRd),
  .cntVal    (cntVal),
  .tioA      (tioA),
  .tioB      (tioB),
  .status    (status),
  .clkOn     (clkOn)
);

// File: tb/wtimer_chan_tb.sv
module wtimer_chan_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int NROWS = 12;

  // Row: {init, cfg[7:0], doSw, doEvt, doTick, expected}
  localparam logic [12:0] ROWS [NROWS] = '{
    {1'b0, 8'h01, 1'b0, 1'b0, 1'b1, 1'b1},
    {1'b1, 8'h02, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b0, 8'h03, 1'b0, 1'b0, 1'b1, 1'b1},
    {1'b1, 8'h09, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b0, 8'h0E, 1'b0, 1'b0, 1'b1, 1'b1},
    {1'b1, 8'h24, 1'b0, 1'b1, 1'b1, 1'b0},
    {1'b0, 8'h04, 1'b0, 1'b1, 1'b1, 1'b1},
    {1'b1, 8'hD0, 1'b1, 1'b1, 1'b0, 1'b0},
    {1'b0, 8'h30, 1'b1, 1'b1, 1'b0, 1'b1},
    {1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1},
    {1'b0, 8'h40, 1'b1, 1'b0, 1'b0, 1'b1},
    {1'b1, 8'h30, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rstN;
  logic [2:0]    clkSel;
  logic [2:0]    extClk;
  logic          tiobIn, cmdClkEn, cmdClkDis, cmdSwTrig;
  logic [1:0]    waveSel, evtSrc, evtEdge;
  logic          evtTrigEn, stopOnRc, disOnRc, statusRd;
  logic [CW-1:0] raVal, rbVal, rcVal, cntVal;
  logic [7:0]    actCfgA, actCfgB;
  logic          tioA, tioB, clkOn;
  logic [3:0]    status;

  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wtimer_chan #(.CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .extClk(extClk), .tiobIn(tiobIn),
    .cmdClkEn(cmdClkEn), .cmdClkDis(cmdClkDis), .cmdSwTrig(cmdSwTrig),
    .waveSel(waveSel), .evtSrc(evtSrc), .evtEdge(evtEdge), .evtTrigEn(evtTrigEn),
    .stopOnRc(stopOnRc), .disOnRc(disOnRc), .raVal(raVal), .rbVal(rbVal),
    .rcVal(rcVal), .actCfgA(actCfgA), .actCfgB(actCfgB), .statusRd(statusRd),
    .cntVal(cntVal), .tioA(tioA), .tioB(tioB), .status(status), .clkOn(clkOn)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic tickExt(input int i);
    extClk[i] = 1'b1; @(negedge clk);
    extClk[i] = 1'b0; @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) tickExt(0);
  endtask

  task automatic swTrig();
    cmdSwTrig = 1'b1; @(negedge clk); cmdSwTrig = 1'b0;
  endtask

  task automatic clkEnable();
    cmdClkEn = 1'b1; @(negedge clk); cmdClkEn = 1'b0;
  endtask

  task automatic clkDisable();
    cmdClkDis = 1'b1; @(negedge clk); cmdClkDis = 1'b0;
  endtask

  task automatic readStatus();
    statusRd = 1'b1; @(negedge clk); statusRd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; clkSel = 3'd5; extClk = '0; tiobIn = 1'b0;
    cmdClkEn = 1'b0; cmdClkDis = 1'b0; cmdSwTrig = 1'b0;
    waveSel = 2'd0; evtSrc = 2'd0; evtEdge = 2'd1; evtTrigEn = 1'b0;
    stopOnRc = 1'b0; disOnRc = 1'b0; statusRd = 1'b0;
    raVal = '0; rbVal = '0; rcVal = '0; actCfgA = '0; actCfgB = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 tioA", int'(tioA), 0);
    chk("R1 tioB", int'(tioB), 0);
    chk("R1 cntVal", int'(cntVal), 0);
    chk("R1 status", int'(status), 0);
    chk("R1 clkOn", int'(clkOn), 0);

    // R2 disable wins over enable in the same cycle
    cmdClkEn = 1'b1; cmdClkDis = 1'b1; @(negedge clk);
    cmdClkEn = 1'b0; cmdClkDis = 1'b0;
    chk("R2 dis wins", int'(clkOn), 0);

    // Action and priority table (R9, R10)
    for (int r = 0; r < NROWS; r++) begin
      logic [12:0] row;
      row = ROWS[r];
      clkDisable(); clkEnable();
      actCfgA = row[12] ? 8'h40 : 8'h00; actCfgB = actCfgA;
      swTrig();
      actCfgA = row[11:4]; actCfgB = row[11:4];
      cmdSwTrig = row[3]; tiobIn = row[2]; extClk[0] = row[1];
      @(negedge clk);
      chk((r < 3) ? "R9 row tioA" : "R10 row tioA", int'(tioA), int'(row[0]));
      chk((r < 3) ? "R9 row tioB" : "R10 row tioB", int'(tioB), int'(row[0]));
      cmdSwTrig = 1'b0; tiobIn = 1'b0; extClk[0] = 1'b0;
      @(negedge clk);
    end

    // R2 outputs low and count held while disabled
    actCfgA = 8'h40; actCfgB = 8'h00;
    swTrig();
    chk("R9 sw set", int'(tioA), 1);
    ticks(3);
    chk("R4 count 3", int'(cntVal), 3);
    clkDisable();
    chk("R2 out low off", int'(tioA), 0);
    ticks(2);
    chk("R2 hold off", int'(cntVal), 3);
    actCfgA = 8'h00;
    clkEnable();

    // R3 internal divider taps and external clock select
    clkSel = 3'd1; swTrig();
    repeat (64) @(negedge clk);
    chk("R3 div8", int'(cntVal), 8);
    clkSel = 3'd0; swTrig();
    repeat (20) @(negedge clk);
    chk("R3 div2", int'(cntVal), 10);
    clkSel = 3'd6; swTrig();
    ticks(2);
    chk("R3 ext0 unselected", int'(cntVal), 0);
    for (int k = 0; k < 3; k++) tickExt(1);
    chk("R3 ext1", int'(cntVal), 3);
    clkSel = 3'd5;

    // R4 wrap and overflow, R11 status
    readStatus(); swTrig();
    ticks(15);
    chk("R4 at max", int'(cntVal), 15);
    chk("R4 no ovf yet", int'(status[0]), 0);
    ticks(1);
    chk("R4 wrap", int'(cntVal), 0);
    chk("R11 all flags", int'(status), 15);
    readStatus();
    chk("R11 cleared", int'(status), 0);
    statusRd = 1'b1; extClk[0] = 1'b1; @(negedge clk);
    statusRd = 1'b0; extClk[0] = 1'b0;
    chk("R11 set wins", int'(status), 14);
    @(negedge clk);

    // R5 up with RC restart
    raVal = 4'd15; rbVal = 4'd15; rcVal = 4'd5; waveSel = 2'd2;
    readStatus(); swTrig();
    ticks(5);
    chk("R5 at rc", int'(cntVal), 5);
    ticks(1);
    chk("R5 restart", int'(cntVal), 0);
    chk("R11 rc flag", int'(status), 8);

    // R6 up-down at all-ones and at RC
    waveSel = 2'd1; swTrig();
    ticks(16);
    chk("R6 turn at max", int'(cntVal), 14);
    ticks(14);
    chk("R6 down to zero", int'(cntVal), 0);
    ticks(1);
    chk("R6 turn at zero", int'(cntVal), 1);
    waveSel = 2'd3; rcVal = 4'd6; swTrig();
    ticks(7);
    chk("R6 turn at rc", int'(cntVal), 5);

    // R7 triggers
    waveSel = 2'd0; rcVal = 4'd15; swTrig();
    ticks(4);
    swTrig();
    chk("R7 sw restart", int'(cntVal), 0);
    ticks(2);
    evtTrigEn = 1'b1; evtSrc = 2'd0; evtEdge = 2'd1;
    tiobIn = 1'b1; @(negedge clk);
    chk("R7 event restart", int'(cntVal), 0);
    tiobIn = 1'b0; @(negedge clk);
    evtTrigEn = 1'b0;
    ticks(3);
    clkDisable(); swTrig();
    chk("R7 ignored off", int'(cntVal), 3);
    clkEnable();

    // R8 event source and edge
    evtSrc = 2'd3; evtEdge = 2'd2; actCfgA = 8'h30;
    extClk[2] = 1'b1; @(negedge clk);
    chk("R8 rise ignored", int'(tioA), 0);
    extClk[2] = 1'b0; @(negedge clk);
    chk("R8 fall toggles", int'(tioA), 1);
    evtEdge = 2'd0;
    extClk[2] = 1'b1; @(negedge clk);
    extClk[2] = 1'b0; @(negedge clk);
    chk("R8 edge none", int'(tioA), 1);
    actCfgA = 8'h00; evtEdge = 2'd1; evtSrc = 2'd0;

    // R12 stop and disable on RC
    rcVal = 4'd3; stopOnRc = 1'b1; swTrig();
    ticks(4);
    chk("R12 stop tick taken", int'(cntVal), 4);
    ticks(2);
    chk("R12 stopped", int'(cntVal), 4);
    swTrig(); ticks(1);
    chk("R12 resumed", int'(cntVal), 1);
    stopOnRc = 1'b0; disOnRc = 1'b1; swTrig();
    ticks(4);
    chk("R12 disabled", int'(clkOn), 0);
    chk("R12 dis count", int'(cntVal), 4);
    disOnRc = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule